// File: doc/BRIEF.md
# USB Power Delivery BMC Packet Framer

This block turns one Power Delivery message into the line waveform on the configuration channel. A requester presents a 16-bit message header and up to seven 32-bit data objects, then pulses a start strobe. The block captures these values and sends the whole frame: a preamble, a start-of-packet ordered set, the header and the objects encoded as 4b5b symbols, a CRC-32 over header and objects, the end-of-packet symbol, and a closing transition. A second strobe sends a hard-reset ordered set in place of a message.

The line is biphase-mark coded. It advances only on a half-bit enable supplied from outside, so the bit rate is set by whoever generates that enable. The output enable and the busy flag cover the whole frame. A one-cycle done pulse marks the end. Analog driving, collision sensing and clock recovery are outside this block.

Top module: `pd_bmc_framer`

## Requirements
- R1: While reset is held, and in the first cycle after it, cc_out, cc_oe, busy and done are all 0.
- R2: When the block is idle, a tx_start pulse captures header_i and objs_i. busy and cc_oe rise at the next clock edge, and cc_out does not move until the next half_en after that edge. A half_en that arrives together with the start is ignored.
- R3: cc_out changes only at a clock edge where half_en is high. Each bit lasts two half_en pulses. The line toggles on the first of them for every bit, and toggles on the second only when the bit is 1.
- R4: A frame opens with 64 preamble bits alternating 0,1,0,1 and starting with 0. Next come three Sync-1 symbols (5'b11000) and one Sync-2 symbol (5'b10001). Every 5-bit symbol is sent bit 0 first.
- R5: The header is sent as four nibbles, least significant first. It is followed by N objects, where N is header bits 14:12. Each object is sent as eight nibbles, least significant first, so its low half goes before its high half. Each nibble is sent as its 5-bit code: 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101.
- R6: After the objects come eight nibbles of a CRC-32, least significant nibble first. The CRC uses polynomial 0x04C11DB7, reflected, with an initial value of all ones and a final inversion. It covers the header bytes and then the object bytes, each in least-significant-byte-first order.
- R7: After the CRC, the end-of-packet symbol 5'b01101 is sent. One extra line toggle follows on the next half_en, then the line is held for one more half_en. At that point busy and cc_oe fall and done is high for exactly one cycle.
- R8: In idle, a hr_start pulse sends the 64-bit preamble, three RST-1 symbols (5'b00111) and one RST-2 symbol (5'b11001), then the closing toggle and hold from R7. No header, objects, CRC or end-of-packet symbol are sent. hr_start wins over a tx_start in the same cycle.
- R9: tx_start, hr_start, header_i and objs_i have no effect on the frame in progress while busy is high.
- R10: A header whose count field is 0 gives a frame with header, CRC and end-of-packet symbol only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_en | input | 1 | Half-bit enable that paces the line |
| tx_start | input | 1 | Start a message frame |
| hr_start | input | 1 | Start a hard-reset frame |
| header_i | input | 16 | Message header; bits 14:12 give the object count |
| objs_i | input | 32*MAX_OBJ | Data objects, object 0 in the low 32 bits |
| cc_out | output | 1 | Biphase-mark coded line level |
| cc_oe | output | 1 | Line driver enable for the whole frame |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse when a frame has ended |

## Verification
Some rules are checked by the assertions on every cycle:
- the line moves only on a half-bit enable;
- every bit opens with a toggle, and a 0 bit holds flat through its second half;
- done is a single cycle that directly follows busy;
- the captured header stays frozen for the whole frame;
- the symbol pointer never passes the final symbol, and a hard reset never goes beyond its four K-codes.

The symbol content itself can only be shown by the bench's scenarios, which compare the line against an independently built expected waveform on every clock: the preamble, the 4b5b codes and nibble order, the CRC value, the end-of-packet symbol and the closing toggle. The same is true of the ignored mid-frame requests, of hard-reset priority, and of the zero-object case under several half-bit enable patterns.

// File: rtl/pd_frm_pkg.sv
`timescale 1ns/1ps
package pd_frm_pkg;
  localparam logic [4:0] K_SYNC1 = 5'b11000;
  localparam logic [4:0] K_SYNC2 = 5'b10001;
  localparam logic [4:0] K_RST1  = 5'b00111;
  localparam logic [4:0] K_RST2  = 5'b11001;
  localparam logic [4:0] K_EOP   = 5'b01101;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  typedef enum logic [2:0] {F_IDLE, F_PRE, F_SYM, F_EDGE, F_HOLD} frm_state_e;

  function automatic logic [4:0] nib_to_code(input logic [3:0] n);
    logic [4:0] c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/pd_crc_nib.sv
`timescale 1ns/1ps
module pd_crc_nib #(
  parameter logic [31:0] POLY = pd_frm_pkg::CRC_POLY_REFL
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        init,
  input  logic        upd,
  input  logic [3:0]  nib,
  output logic [31:0] crc_o
);
  logic [31:0] crc_q;
  logic [31:0] nxt;

  // reflected register: one nibble, bit 0 first
  always_comb begin
    nxt = crc_q;
    for (int i = 0; i < 4; i++) begin
      if (nxt[0] ^ nib[i]) nxt = (nxt >> 1) ^ POLY;
      else                 nxt = nxt >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || init) crc_q <= '1;
    else if (upd)    crc_q <= nxt;
  end

  assign crc_o = ~crc_q;

  // R6: the running value only moves on an update or a restart
  a_r6_crc_hold: assert property (@(posedge clk) disable iff (rst)
    (!init && !upd) |=> $stable(crc_q));
endmodule

// File: rtl/pd_sym_sel.sv
`timescale 1ns/1ps
module pd_sym_sel #(
  parameter int MAX_OBJ = 7,
  parameter int IDX_W   = 7
) (
  input  logic                  hr_mode,
  input  logic [IDX_W-1:0]      sym_idx,
  input  logic [15:0]           hdr,
  input  logic [2:0]            cnt,
  input  logic [MAX_OBJ*32-1:0] objs,
  input  logic [31:0]           crc_fin,
  output logic [4:0]            code,
  output logic [3:0]            nib,
  output logic                  is_data,
  output logic [IDX_W-1:0]      last_idx
);
  import pd_frm_pkg::*;

  int idx, n_data, d;

  always_comb begin
    idx     = int'(sym_idx);
    n_data  = 4 + 8 * int'(cnt);
    d       = 0;
    nib     = '0;
    is_data = 1'b0;
    code    = K_EOP;
    if (hr_mode) begin
      code = (idx < 3) ? K_RST1 : K_RST2;
    end else if (idx < 3) begin
      code = K_SYNC1;
    end else if (idx == 3) begin
      code = K_SYNC2;
    end else if (idx < 4 + n_data) begin
      is_data = 1'b1;
      d = idx - 4;
      if (d < 4) nib = hdr[d*4 +: 4];
      else       nib = objs[(d-4)*4 +: 4];
      code = nib_to_code(nib);
    end else if (idx < 12 + n_data) begin
      d = idx - 4 - n_data;
      nib = crc_fin[d*4 +: 4];
      code = nib_to_code(nib);
    end
  end

  assign last_idx = hr_mode ? IDX_W'(3) : IDX_W'(16 + 8 * int'(cnt));
endmodule

// File: rtl/pd_bmc_coder.sv
`timescale 1ns/1ps
module pd_bmc_coder (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic bit_en,
  input  logic edge_en,
  input  logic bit_i,
  output logic line_o,
  output logic half_o
);
  logic line_q, half_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
      half_q <= 1'b0;
    end else if (tick && bit_en) begin
      if (!half_q) begin
        line_q <= ~line_q;
        half_q <= 1'b1;
      end else begin
        if (bit_i) line_q <= ~line_q;
        half_q <= 1'b0;
      end
    end else if (tick && edge_en) begin
      line_q <= ~line_q;
    end
  end

  assign line_o = line_q;
  assign half_o = half_q;

  // R3: every bit opens with a transition
  a_r3_bit_edge: assert property (@(posedge clk) disable iff (rst)
    (tick && bit_en && !half_q) |=> (line_q != $past(line_q)));
  // R3: a zero bit stays flat in its second half
  a_r3_zero_flat: assert property (@(posedge clk) disable iff (rst)
    (tick && bit_en && half_q && !bit_i) |=> $stable(line_q));
endmodule

// File: rtl/pd_bmc_framer.sv
`timescale 1ns/1ps
module pd_bmc_framer #(
  parameter int MAX_OBJ  = 7,
  parameter int PRE_BITS = 64,
  parameter int CNT_LSB  = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  half_en,
  input  logic                  tx_start,
  input  logic                  hr_start,
  input  logic [15:0]           header_i,
  input  logic [MAX_OBJ*32-1:0] objs_i,
  output logic                  cc_out,
  output logic                  cc_oe,
  output logic                  busy,
  output logic                  done
);
  import pd_frm_pkg::*;

  localparam int OBJ_W   = MAX_OBJ * 32;
  localparam int PRE_W   = $clog2(PRE_BITS);
  localparam int IDX_W   = $clog2(16 + 8 * MAX_OBJ + 1);
  localparam int CNT_MAX = (MAX_OBJ > 7) ? 7 : MAX_OBJ;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_BITS - 1);

  frm_state_e       state;
  logic             hr_q, busy_q, done_q;
  logic [15:0]      hdr_q;
  logic [OBJ_W-1:0] obj_q;
  logic [PRE_W-1:0] pre_cnt;
  logic [IDX_W-1:0] sym_idx, last_idx;
  logic [2:0]       bis;
  logic [2:0]       cnt_raw, cnt_eff;
  logic [4:0]       sym_code;
  logic [3:0]       nib;
  logic             is_data, cur_bit, half_ph, bit_end, in_bits;
  logic             accept;
  logic [31:0]      crc_fin;

  assign cnt_raw = hdr_q[CNT_LSB +: 3];
  assign cnt_eff = (int'(cnt_raw) > CNT_MAX) ? 3'(CNT_MAX) : cnt_raw;
  assign accept  = (state == F_IDLE) && (tx_start || hr_start);
  assign in_bits = (state == F_PRE) || (state == F_SYM);
  assign cur_bit = (state == F_PRE) ? pre_cnt[0] : sym_code[bis];
  assign bit_end = half_en && in_bits && half_ph;

  pd_sym_sel #(.MAX_OBJ(MAX_OBJ), .IDX_W(IDX_W)) u_sel (
    .hr_mode (hr_q),
    .sym_idx (sym_idx),
    .hdr     (hdr_q),
    .cnt     (cnt_eff),
    .objs    (obj_q),
    .crc_fin (crc_fin),
    .code    (sym_code),
    .nib     (nib),
    .is_data (is_data),
    .last_idx(last_idx)
  );

  pd_crc_nib u_crc (
    .clk  (clk),
    .rst  (rst),
    .init (accept),
    .upd  (bit_end && (state == F_SYM) && (bis == 3'd4) && is_data),
    .nib  (nib),
    .crc_o(crc_fin)
  );

  pd_bmc_coder u_bmc (
    .clk    (clk),
    .rst    (rst),
    .tick   (half_en),
    .bit_en (in_bits),
    .edge_en(state == F_EDGE),
    .bit_i  (cur_bit),
    .line_o (cc_out),
    .half_o (half_ph)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= F_IDLE;
      hr_q    <= 1'b0;
      hdr_q   <= '0;
      obj_q   <= '0;
      pre_cnt <= '0;
      sym_idx <= '0;
      bis     <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        F_IDLE: if (accept) begin
          state   <= F_PRE;
          hr_q    <= hr_start;
          hdr_q   <= header_i;
          obj_q   <= objs_i;
          pre_cnt <= '0;
          sym_idx <= '0;
          bis     <= '0;
          busy_q  <= 1'b1;
        end
        F_PRE: if (bit_end) begin
          if (pre_cnt == PRE_LAST) state <= F_SYM;
          else pre_cnt <= pre_cnt + 1'b1;
        end
        F_SYM: if (bit_end) begin
          if (bis == 3'd4) begin
            bis <= '0;
            if (sym_idx == last_idx) state <= F_EDGE;
            else sym_idx <= sym_idx + 1'b1;
          end else begin
            bis <= bis + 1'b1;
          end
        end
        F_EDGE: if (half_en) state <= F_HOLD;
        F_HOLD: if (half_en) begin
          state  <= F_IDLE;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
        default: state <= F_IDLE;
      endcase
    end
  end

  assign busy  = busy_q;
  assign cc_oe = busy_q;
  assign done  = done_q;

  // R3: no line movement without a half-bit enable
  a_r3_line_on_tick: assert property (@(posedge clk) disable iff (rst)
    !half_en |=> $stable(cc_out));
  // R7: done lasts one cycle and follows the end of busy
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  // R9: captured frame content is frozen while busy
  a_r9_hdr_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(hdr_q));
  // R5: the symbol pointer never runs past the last symbol
  a_r5_idx_bound: assert property (@(posedge clk) disable iff (rst)
    (state == F_SYM) |-> (sym_idx <= last_idx));
  // R8: a hard reset stops after four K-codes
  a_r8_hr_short: assert property (@(posedge clk) disable iff (rst)
    (state == F_SYM && hr_q) |-> (sym_idx < IDX_W'(4)));
endmodule

// File: tb/pd_bmc_framer_tb.sv
`timescale 1ns/1ps
module pd_bmc_framer_tb;
  localparam int NOBJ = 7;

  logic clk = 1'b0;
  logic rst, half_en, tx_start, hr_start;
  logic [15:0] hdr_drv;
  logic [NOBJ*32-1:0] obj_drv;
  logic cc_out, cc_oe, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  // reference model state
  logic m_line = 1'b0, m_busy = 1'b0, m_done = 1'b0;
  logic tq[$];
  logic bq[$];

  always #2 clk = ~clk;

  pd_bmc_framer #(.MAX_OBJ(NOBJ)) u_dut (
    .clk(clk), .rst(rst), .half_en(half_en), .tx_start(tx_start),
    .hr_start(hr_start), .header_i(hdr_drv), .objs_i(obj_drv),
    .cc_out(cc_out), .cc_oe(cc_oe), .busy(busy), .done(done)
  );

  function automatic logic [4:0] enc5(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  function automatic void push_sym(input logic [4:0] c);
    for (int i = 0; i < 5; i++) bq.push_back(c[i]);
  endfunction

  function automatic void push_pre();
    bq.delete();
    for (int i = 0; i < 64; i++) bq.push_back(logic'(i % 2));
  endfunction

  function automatic void bits_to_ticks();
    tq.delete();
    foreach (bq[i]) begin
      tq.push_back(1'b1);
      tq.push_back(bq[i]);
    end
    tq.push_back(1'b1);
    tq.push_back(1'b0);
  endfunction

  function automatic logic [31:0] crc_ref(input logic [7:0] by[$]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (by[i]) begin
      c ^= {24'h0, by[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic void build_pkt(input logic [15:0] h, input logic [NOBJ*32-1:0] o);
    int n = int'(h[14:12]);
    logic [7:0] by[$];
    logic [31:0] crc;
    push_pre();
    push_sym(5'b11000); push_sym(5'b11000); push_sym(5'b11000); push_sym(5'b10001);
    by.push_back(h[7:0]); by.push_back(h[15:8]);
    for (int i = 0; i < 4; i++) push_sym(enc5(h[i*4 +: 4]));
    for (int w = 0; w < n; w++) begin
      for (int i = 0; i < 8; i++) push_sym(enc5(o[w*32 + i*4 +: 4]));
      for (int b = 0; b < 4; b++) by.push_back(o[w*32 + b*8 +: 8]);
    end
    crc = crc_ref(by);
    for (int i = 0; i < 8; i++) push_sym(enc5(crc[i*4 +: 4]));
    push_sym(5'b01101);
    bits_to_ticks();
  endfunction

  function automatic void build_hr();
    push_pre();
    push_sym(5'b00111); push_sym(5'b00111); push_sym(5'b00111); push_sym(5'b11001);
    bits_to_ticks();
  endfunction

  function automatic void model_step(input logic he, input logic ts, input logic hs);
    m_done = 1'b0;
    if (!m_busy) begin
      if (hs) begin build_hr(); m_busy = 1'b1; end
      else if (ts) begin build_pkt(hdr_drv, obj_drv); m_busy = 1'b1; end
    end else if (he) begin
      if (tq.pop_front()) m_line = ~m_line;
      if (tq.size() == 0) begin m_busy = 1'b0; m_done = 1'b1; end
    end
  endfunction

  task automatic compare();
    checks++;
    if (cc_out !== m_line || cc_oe !== m_busy || busy !== m_busy || done !== m_done) begin
      errors++;
      $display("FAIL %s: line/oe/busy/done got %b%b%b%b exp %b%b%b%b at %0t",
               cur_req, cc_out, cc_oe, busy, done, m_line, m_busy, m_busy, m_done, $time);
    end
  endtask

  task automatic cyc(input logic he, input logic ts, input logic hs);
    half_en = he; tx_start = ts; hr_start = hs;
    model_step(he, ts, hs);
    @(negedge clk);
    compare();
  endtask

  task automatic run_frame(input int mode, input logic ts, input logic hs,
                           input int poke, input int exp_ticks);
    int ticks = 0;
    int k = 0;
    cyc(1'b1, ts, hs);
    while (m_busy && k < 30000) begin
      logic he;
      case (mode)
        0:       he = (k % 2 == 0);
        1:       he = 1'b1;
        default: he = (k % 3 == 0);
      endcase
      if (he) ticks++;
      if (k == poke) begin
        hdr_drv = ~hdr_drv;
        obj_drv = ~obj_drv;
        cyc(he, 1'b1, 1'b1);
      end else begin
        cyc(he, 1'b0, 1'b0);
      end
      k++;
    end
    checks++;
    if (ticks != exp_ticks) begin
      errors++;
      $display("FAIL R3 %s: frame took %0d half-bit enables, expected %0d", cur_req, ticks, exp_ticks);
    end
  endtask

  function automatic int pkt_ticks(input int n);
    return 2 * (64 + 5 * (17 + 8 * n)) + 2;
  endfunction

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      $display("FAIL R7 watchdog: frame never completed, got running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; half_en = 1'b0; tx_start = 1'b0; hr_start = 1'b0;
    hdr_drv = '0; obj_drv = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (cc_out !== 1'b0 || cc_oe !== 1'b0 || busy !== 1'b0 || done !== 1'b0) begin
      errors++;
      $display("FAIL R1: outputs got %b%b%b%b expected 0000", cc_out, cc_oe, busy, done);
    end
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R1";
    compare();

    // R10 with R2 R4 R5 R6 R7: zero-object message, half_en every other cycle
    cur_req = "R2 R4 R5 R6 R7 R10";
    hdr_drv = 16'h0041;
    run_frame(0, 1'b1, 1'b0, -1, pkt_ticks(0));

    // R5 R6 R9: two objects, half_en every cycle, mid-frame requests ignored
    cur_req = "R5 R6 R9";
    hdr_drv = 16'h2161;
    obj_drv = '0;
    obj_drv[31:0]  = 32'h1234ABCD;
    obj_drv[63:32] = 32'hF00D0001;
    run_frame(1, 1'b1, 1'b0, 300, pkt_ticks(2));

    // R8: hard reset wins over a simultaneous message request
    cur_req = "R8";
    hdr_drv = 16'h1042;
    run_frame(0, 1'b1, 1'b1, -1, 2 * (64 + 20) + 2);

    // R5 R6: full seven objects, sparse half_en
    cur_req = "R5 R6 R3";
    hdr_drv = 16'h71A3;
    for (int w = 0; w < NOBJ; w++) obj_drv[w*32 +: 32] = 32'h01234567 * (w + 3) ^ 32'hA5A50F0F;
    run_frame(2, 1'b1, 1'b0, -1, pkt_ticks(7));

    // R2 R7: back-to-back one-object frame right after done
    cur_req = "R2 R7";
    hdr_drv = 16'h1A5F;
    obj_drv[31:0] = 32'h00000000;
    run_frame(0, 1'b1, 1'b0, -1, pkt_ticks(1));

    repeat (4) cyc(1'b1, 1'b0, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule